// File: doc/BRIEF.md
# Transition-Count Signature Checker

This block watches a group of digital lines driven by a module under test while a fixed stimulus runs. For each line it counts how often the level changes. Rising and falling edges both count. A good module gives the same exact count on every line each time the same stimulus is applied, so each line's total works as a signature.

Before or during a run, the expected total for each line is written through a load port. A start pulse clears the counters and any earlier verdict. A window-active input then marks the stretch of clock cycles in which changes are counted.

When the window closes, every line's total is compared with its expected value. The block then gives a per-line fail flag, a module-level fail output and a one-cycle result-valid pulse. Any line's running or final total can be read through a channel selector, for display.

Top module: `tcount_sig_checker`

## Requirements
- R1: After reset, every channel count, every expected value and every fail flag is zero, and `res_valid_o` is low.
- R2: While counting is enabled, a change of a monitored line in either direction (0 to 1 or 1 to 0) between two consecutive clock samples adds one to that channel's count.
- R3: A channel count is CNT_W bits wide (16 by default) and stays at its maximum value (65535 by default) instead of wrapping.
- R4: Counting is enabled on a clock edge only if `win_i` was high at that edge and also at the previous edge, counted from the last start. So the first sample of a window is a baseline, and level changes while `win_i` is low are never counted.
- R5: A `start_i` pulse clears all channel counts and all fail flags, and suppresses counting and window closing on that edge.
- R6: At window close, channel n's fail flag (`ch_fail_o` bit n) is set if its count differs from its expected value and cleared if the two are exactly equal.
- R7: `mod_fail_o` is high exactly when at least one `ch_fail_o` bit is high.
- R8: The window closes at the first clock edge that samples `win_i` low after counting was enabled. `res_valid_o` is high for exactly the one cycle after that edge, and the fail flags update at that same edge.
- R9: When `exp_we_i` is high at a clock edge, `exp_val_i` becomes the expected value of the channel numbered `exp_sel_i`. No other channel's expected value changes.
- R10: `cnt_o` shows, without a register in the path, the current count of the channel numbered `cnt_sel_i`.
- R11: Fail flags and counts hold their values after a close until the next start, whatever the monitored lines do while `win_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that clears counts and verdicts |
| win_i | input | 1 | Window active; changes are counted while it stays high |
| mon_i | input | NUM_CH | Monitored lines, already synchronous to clk |
| exp_we_i | input | 1 | Write strobe for an expected count |
| exp_sel_i | input | SEL_W | Channel number for the expected-count write |
| exp_val_i | input | CNT_W | Expected count value |
| cnt_sel_i | input | SEL_W | Channel number whose count appears on cnt_o |
| cnt_o | output | CNT_W | Count of the selected channel |
| ch_fail_o | output | NUM_CH | Per-channel mismatch flags |
| mod_fail_o | output | 1 | High when any channel failed |
| res_valid_o | output | 1 | One-cycle pulse after the window closes |

## Verification
A line sample driven in one cycle changes the count at the next clock edge, so `cnt_o` is due one cycle after the sample. The bench reads it half a cycle after that edge, after setting `cnt_sel_i` in the low phase.

The close edge is the first edge that sees `win_i` low. The fail flags and `res_valid_o` are due in the cycle right after it, and the bench checks them on that falling edge. It checks on the following falling edge that the pulse has dropped.

A start pulse clears the counts at its edge, so the zero counts are checked one falling edge later. All stimulus is driven on falling edges, so no check depends on the order of processes at the rising edge.

// File: rtl/tsc_pkg.sv
// Shared types for the transition-count signature checker.
package tsc_pkg;

    // Window tracking: IDLE means the previous edge did not see an open window.
    typedef enum logic {
        WS_IDLE = 1'b0,
        WS_LIVE = 1'b1
    } win_state_e;

endpackage

// File: rtl/tsc_window_ctrl.sv
// Window control: decides on which edges counting is allowed, detects the
// closing edge and produces the one-cycle result-valid pulse.
// Assumes start_i and win_i are synchronous to clk.
module tsc_window_ctrl
    import tsc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic win_i,
    output logic count_en_o,
    output logic close_o,
    output logic res_valid_o
);

    win_state_e state_q;

    // Remember whether the previous edge saw an open window since the last start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
        end else if (start_i) begin
            state_q <= WS_IDLE;
        end else begin
            state_q <= win_i ? WS_LIVE : WS_IDLE;
        end
    end

    // Count only on the second and later samples of a window; close on the first low sample.
    always_comb begin
        count_en_o = win_i && (state_q == WS_LIVE) && !start_i;
        close_o    = !win_i && (state_q == WS_LIVE) && !start_i;
    end

    // Result-valid follows the closing edge by one register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid_o <= 1'b0;
        end else begin
            res_valid_o <= close_o;
        end
    end

endmodule

// File: rtl/tsc_chan_counter.sv
// One channel: detects a level change against the previous sample and keeps
// a saturating count of changes. Assumes line_i is synchronous to clk.
module tsc_chan_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic             line_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic prev_q;
    logic toggled;

    // Hold the previous sample of the line on every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= line_i;
        end
    end

    // A change in either direction is a transition.
    always_comb begin
        toggled = line_i ^ prev_q;
    end

    // Clear on start, otherwise add one per counted transition, stopping at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clr_i) begin
            cnt_o <= '0;
        end else if (en_i && toggled && (cnt_o != CNT_MAX)) begin
            cnt_o <= cnt_o + CNT_W'(1);
        end
    end

endmodule

// File: rtl/tsc_expect_bank.sv
// Register bank holding one expected count per channel, written one entry
// at a time. Assumes the write port is driven synchronously to clk.
module tsc_expect_bank #(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 16,
    parameter int SEL_W  = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we_i,
    input  logic [SEL_W-1:0]              sel_i,
    input  logic [CNT_W-1:0]              val_i,
    output logic [NUM_CH-1:0][CNT_W-1:0]  exp_o
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_entry
        // Store the value when this entry is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                exp_o[g] <= '0;
            end else if (we_i && (sel_i == SEL_W'(g))) begin
                exp_o[g] <= val_i;
            end
        end
    end

endmodule

// File: rtl/tsc_verdict.sv
// Compares every channel count with its expected value on the closing edge
// and holds the per-channel verdicts until the next start.
module tsc_verdict #(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr_i,
    input  logic                          close_i,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  cnt_i,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  exp_i,
    output logic [NUM_CH-1:0]             fail_o,
    output logic                          any_fail_o
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp
        // Latch the exact-equality verdict for this channel at close.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fail_o[g] <= 1'b0;
            end else if (clr_i) begin
                fail_o[g] <= 1'b0;
            end else if (close_i) begin
                fail_o[g] <= (cnt_i[g] != exp_i[g]);
            end
        end
    end

    // The module fails when any channel fails.
    always_comb begin
        any_fail_o = |fail_o;
    end

endmodule

// File: rtl/tcount_sig_checker.sv
// Top level: per-channel transition counters, expected-count bank, window
// control and verdict logic. Assumes the monitored lines are already
// synchronous to clk and that start_i is a single-cycle pulse.
module tcount_sig_checker #(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 16,
    parameter int SEL_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              win_i,
    input  logic [NUM_CH-1:0] mon_i,
    input  logic              exp_we_i,
    input  logic [SEL_W-1:0]  exp_sel_i,
    input  logic [CNT_W-1:0]  exp_val_i,
    input  logic [SEL_W-1:0]  cnt_sel_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [NUM_CH-1:0] ch_fail_o,
    output logic              mod_fail_o,
    output logic              res_valid_o
);

    logic                         count_en;
    logic                         close_p;
    logic [NUM_CH-1:0][CNT_W-1:0] cnt_all;
    logic [NUM_CH-1:0][CNT_W-1:0] exp_all;

    tsc_window_ctrl u_win (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .win_i       (win_i),
        .count_en_o  (count_en),
        .close_o     (close_p),
        .res_valid_o (res_valid_o)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        tsc_chan_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (start_i),
            .en_i   (count_en),
            .line_i (mon_i[g]),
            .cnt_o  (cnt_all[g])
        );
    end

    tsc_expect_bank #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_exp (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (exp_we_i),
        .sel_i (exp_sel_i),
        .val_i (exp_val_i),
        .exp_o (exp_all)
    );

    tsc_verdict #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_vrd (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (start_i),
        .close_i    (close_p),
        .cnt_i      (cnt_all),
        .exp_i      (exp_all),
        .fail_o     (ch_fail_o),
        .any_fail_o (mod_fail_o)
    );

    // Present the selected channel count for display.
    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (cnt_sel_i == SEL_W'(i)) begin
                cnt_o = cnt_all[i];
            end
        end
    end

endmodule

// File: rtl/tsc_checker.sv
// Port-level temporal checks for the signature checker, attached by bind.
module tsc_checker #(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 16,
    parameter int SEL_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              win_i,
    input logic [SEL_W-1:0]  cnt_sel_i,
    input logic [CNT_W-1:0]  cnt_o,
    input logic [NUM_CH-1:0] ch_fail_o,
    input logic              mod_fail_o,
    input logic              res_valid_o
);

    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (cnt_sel_i != $past(cnt_sel_i)) || (cnt_o == $past(cnt_o))
                     || (cnt_o == $past(cnt_o) + CNT_W'(1)));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == CMAX && !start_i) |=> (cnt_o == CMAX) || (cnt_sel_i != $past(cnt_sel_i)));

    p_quiet_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_i && !start_i) |=> (cnt_o == $past(cnt_o)) || (cnt_sel_i != $past(cnt_sel_i)));

    p_start_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (cnt_o == '0) && (ch_fail_o == '0) && !res_valid_o);

    p_fail_at_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_fail_o) |-> $rose(res_valid_o));

    p_pulse_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o);

    p_valid_after_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_valid_o) |-> !$past(win_i) && !$past(start_i));

    p_flags_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ch_fail_o) |-> res_valid_o || $past(start_i));

endmodule

bind tcount_sig_checker tsc_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .SEL_W(SEL_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .win_i       (win_i),
    .cnt_sel_i   (cnt_sel_i),
    .cnt_o       (cnt_o),
    .ch_fail_o   (ch_fail_o),
    .mod_fail_o  (mod_fail_o),
    .res_valid_o (res_valid_o)
);

// File: tb/tcount_sig_checker_tb_top.sv
`timescale 1ns/1ps
module tcount_sig_checker_tb_top;

    localparam int NCH = 8;
    localparam int CW  = 16;
    localparam int SW  = 3;
    localparam int MAXV = 65535;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          win_i = 1'b0;
    logic [NCH-1:0] mon_i = '0;
    logic          exp_we_i = 1'b0;
    logic [SW-1:0] exp_sel_i = '0;
    logic [CW-1:0] exp_val_i = '0;
    logic [SW-1:0] cnt_sel_i = '0;
    logic [CW-1:0] cnt_o;
    logic [NCH-1:0] ch_fail_o;
    logic          mod_fail_o;
    logic          res_valid_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    int model [NCH];
    logic [NCH-1:0] samp [64];

    always #2.5 clk = ~clk;

    tcount_sig_checker #(.NUM_CH(NCH), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .win_i(win_i), .mon_i(mon_i),
        .exp_we_i(exp_we_i), .exp_sel_i(exp_sel_i), .exp_val_i(exp_val_i),
        .cnt_sel_i(cnt_sel_i), .cnt_o(cnt_o), .ch_fail_o(ch_fail_o),
        .mod_fail_o(mod_fail_o), .res_valid_o(res_valid_o)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Read one channel count through the selector, in the low clock phase.
    task automatic read_cnt(input int ch, output int v);
        cnt_sel_i = SW'(ch);
        #0.2;
        v = int'(cnt_o);
    endtask

    task automatic load_exp(input int ch, input int val);
        @(negedge clk);
        exp_we_i = 1'b1; exp_sel_i = SW'(ch); exp_val_i = CW'(val);
        @(negedge clk);
        exp_we_i = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        win_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Expected transitions per channel, counted from the requirements.
    function automatic int count_changes(input int ch, input int n);
        int c = 0;
        for (int i = 1; i < n; i++)
            if (samp[i][ch] != samp[i-1][ch]) c++;
        return (c > MAXV) ? MAXV : c;
    endfunction

    // Close the window, then check verdicts, the valid pulse and counts.
    task automatic close_and_check(input logic [NCH-1:0] fmask);
        int v;
        @(negedge clk);
        win_i = 1'b0;
        @(negedge clk);
        chk("R8 valid pulse high", res_valid_o, 1);
        chk("R6 per-channel flags", ch_fail_o, fmask);
        chk("R7 module fail", mod_fail_o, (fmask != 0));
        for (int ch = 0; ch < NCH; ch++) begin
            read_cnt(ch, v);
            chk($sformatf("R2/R10 count ch%0d", ch), v, model[ch]);
        end
        @(negedge clk);
        chk("R8 valid pulse one cycle", res_valid_o, 0);
    endtask

    // mode 0: random samples; mode 1: directed edge pattern.
    task automatic run_window(input int n, input int mode, input int bad_ch);
        logic [NCH-1:0] fmask = '0;
        for (int i = 0; i < n; i++) begin
            if (mode == 1)
                samp[i] = {5'b0, NCH'(i < 4) , NCH'(i >= 6), 1'(i[0])} ;
            else if (i > 0 && ($urandom % 3) == 0)
                samp[i] = samp[i-1];
            else
                samp[i] = NCH'($urandom);
        end
        for (int ch = 0; ch < NCH; ch++) begin
            model[ch] = count_changes(ch, n);
            load_exp(ch, model[ch] + ((ch == bad_ch) ? 1 : 0));
            if (ch == bad_ch) fmask[ch] = 1'b1;
        end
        pulse_start();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            mon_i = (mode == 1) ? '1 : NCH'($urandom);
        end
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            win_i = 1'b1; mon_i = samp[i];
        end
        close_and_check(fmask);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int v;
        logic [NCH-1:0] keep;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 valid low", res_valid_o, 0);
        chk("R1 flags clear", ch_fail_o, 0);
        chk("R1 module fail low", mod_fail_o, 0);
        for (int ch = 0; ch < NCH; ch++) begin
            read_cnt(ch, v);
            chk("R1 count zero", v, 0);
        end
        // R1 expected values zero: an empty window passes on every channel.
        pulse_start();
        @(negedge clk); win_i = 1'b1; mon_i = '0;
        for (int ch = 0; ch < NCH; ch++) model[ch] = 0;
        close_and_check('0);

        // R4 changes while the window is low are ignored.
        pulse_start();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); mon_i = ~mon_i;
        end
        @(negedge clk);
        read_cnt(0, v);
        chk("R4 no count with window low", v, 0);

        // Directed edges: both directions counted, baseline not counted (R2, R4, R9).
        run_window(10, 1, -1);
        chk("R2 directed ch0 toggles", model[0], 9);
        // R9: a single mismatched expected value fails only its channel.
        run_window(10, 1, 2);

        // R11 verdict and counts hold while idle.
        keep = ch_fail_o;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); mon_i = NCH'($urandom);
        end
        chk("R11 flags hold", ch_fail_o, keep);
        read_cnt(0, v);
        chk("R11 count holds", v, 9);

        // Random windows, some with one wrong expected value (R6, R7, R9).
        for (int k = 0; k < 8; k++)
            run_window(5 + int'($urandom % 59), 0, (k % 2 == 0) ? int'($urandom % NCH) : -1);

        // R5 start clears counts and flags.
        pulse_start();
        chk("R5 flags cleared", ch_fail_o, 0);
        chk("R5 module fail cleared", mod_fail_o, 0);
        for (int ch = 0; ch < NCH; ch++) begin
            read_cnt(ch, v);
            chk("R5 count cleared", v, 0);
        end

        // R3 saturation: 65539 transitions on every line, ch3 expects one less than max.
        for (int ch = 0; ch < NCH; ch++) begin
            model[ch] = MAXV;
            load_exp(ch, (ch == 3) ? MAXV - 1 : MAXV);
        end
        pulse_start();
        for (int i = 0; i < 65540; i++) begin
            @(negedge clk);
            win_i = 1'b1; mon_i = (i % 2 == 1) ? '1 : '0;
        end
        close_and_check(NCH'(8));

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule